// File: doc/BRIEF.md
# If-Then Conditional Block Sequencer

This unit sits beside an instruction decoder and predicates short runs of instructions. When the decoder issues an If-Then directive outside an active block, the sequencer stores a 4-bit base condition and a small then/else pattern. It then tracks the next one to four issued instructions. For each of them it reports whether the instruction sits inside the block, whether its predicate holds on the condition flags presented in that same cycle, and whether it is the final slot of the block.

The block also polices where instructions are placed. A program-counter-writing instruction anywhere but the final slot is flagged as an illegal placement, and so is a directive issued while a block is already running. While a block is open, the unit raises a lock output that tells the flag logic to keep short-form flag-setting ALU results from updating the flags. An exception entry or a synchronous reset drops any open block.

Issue is a plain per-cycle strobe. The sequencer never stalls the decoder, so there is no ready signal and no back-pressure: every strobe is taken in the cycle it appears. The predicate outputs are combinational on the current strobe and flags. Slot state advances on the following clock edge.

Top module: `it_block_seq`

## Requirements
- R1: A directive (`dir_valid`) issued while no block is open opens a block of `dir_extra`+1 slots, from 1 up to MAX_SLOTS (4). From the next cycle `in_block` is 1.
- R2: Each issued instruction or directive while a block is open consumes exactly one slot. Idle cycles consume none. `last_slot` is 1 during the final slot, and `in_block` is 0 after that slot has been consumed.
- R3: The first slot uses the base condition. Slot k (k = 1..3) uses the inverse of the base condition when `dir_pattern[k-1]` is 1 (else), and the base condition when it is 0 (then).
- R4: Condition codes are EQ=0 (Z), NE=1 (!Z), CS=2 (C), CC=3 (!C), MI=4 (N), PL=5 (!N), VS=6 (V), VC=7 (!V), HI=8 (C&!Z), LS=9 (!C|Z), GE=10 (N==V), LT=11 (N!=V), GT=12 (!Z&N==V), LE=13 (Z|N!=V), and AL=14 (always). Code 15 also means always. Inverting a code flips its bit 0. An inverted always-code still means always.
- R5: Outside a block, `exec_en` is 1 and `in_block` is 0.
- R6: Flags are taken from the inputs in the same cycle as each slot, so a flag change made by an earlier slot alters the predicate of a later slot.
- R7: An instruction with `ins_writes_pc`=1 raises `bad_place` when it is in a block slot that is not the last one. It does not raise `bad_place` in the last slot or outside a block.
- R8: A directive issued inside an open block raises `bad_place`, consumes one slot and does not reload the condition or the pattern.
- R9: `flag_lock` is 1 exactly while a block is open and 0 otherwise.
- R10: `exc_entry` or a synchronous low `rst_n` closes any open block from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exc_entry | input | 1 | Exception entry; drops the open block |
| dir_valid | input | 1 | If-Then directive issued this cycle |
| dir_cond | input | 4 | Base condition code of the directive |
| dir_extra | input | 2 | Number of slots beyond the first (0..3) |
| dir_pattern | input | 3 | Bit k-1 set: slot k uses the inverse condition |
| ins_valid | input | 1 | Ordinary instruction issued this cycle |
| ins_writes_pc | input | 1 | Issued instruction can write the program counter |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| in_block | output | 1 | A block is open; the current slot is predicated |
| last_slot | output | 1 | The current slot is the final one of the block |
| exec_en | output | 1 | The current instruction may take effect |
| bad_place | output | 1 | Illegal placement of the issued instruction |
| flag_lock | output | 1 | Short-form flag updates are suppressed |

## Verification
The assertions assume that the decoder never raises `dir_valid` and `ins_valid` in the same cycle. They also assume that the strobes are low while reset is applied. The stimulus drives every strobe from tasks that assert exactly one of them for one cycle and then clear it, so both conditions always hold. Flags are driven together with each instruction strobe. This matches the assumption that a slot's predicate depends only on flags presented in its own cycle.

// File: rtl/it_seq_pkg.sv
package it_seq_pkg;
  typedef enum logic [3:0] {
    CND_EQ = 4'd0,  CND_NE = 4'd1,  CND_CS = 4'd2,  CND_CC = 4'd3,
    CND_MI = 4'd4,  CND_PL = 4'd5,  CND_VS = 4'd6,  CND_VC = 4'd7,
    CND_HI = 4'd8,  CND_LS = 4'd9,  CND_GE = 4'd10, CND_LT = 4'd11,
    CND_GT = 4'd12, CND_LE = 4'd13, CND_AL = 4'd14, CND_NV = 4'd15
  } cond_code_e;

  localparam int COND_W = 4;
endpackage

// File: rtl/it_cond_eval.sv
module it_cond_eval
  import it_seq_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic              invert,
  input  logic              fn,
  input  logic              fz,
  input  logic              fc,
  input  logic              fv,
  output logic              pass
);
  logic [2:0] grp;
  logic       base;
  logic       sense;

  assign grp   = cond[3:1];
  assign sense = cond[0] ^ invert;

  // Even member of each pair is the positive test; bit 0 negates it.
  always_comb begin
    case (grp)
      3'd0:    base = fz;
      3'd1:    base = fc;
      3'd2:    base = fn;
      3'd3:    base = fv;
      3'd4:    base = fc & ~fz;
      3'd5:    base = (fn == fv);
      3'd6:    base = ~fz & (fn == fv);
      default: base = 1'b1;
    endcase
  end

  assign pass = (grp == 3'd7) ? 1'b1 : (base ^ sense);
endmodule

// File: rtl/it_slot_tracker.sv
module it_slot_tracker #(
  parameter int MAX_SLOTS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         load,
  input  logic                         consume,
  input  logic [$clog2(MAX_SLOTS)-1:0] extra,
  input  logic [MAX_SLOTS-2:0]         pattern,
  output logic                         active,
  output logic                         last,
  output logic                         cur_inv
);
  localparam int CW = $clog2(MAX_SLOTS + 1);
  localparam int PW = MAX_SLOTS - 1;

  logic [CW-1:0] remain;
  logic [PW-1:0] pat_q;
  logic          inv_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      remain <= '0;
      pat_q  <= '0;
      inv_q  <= 1'b0;
    end else if (load) begin
      remain <= CW'(extra) + CW'(1);
      pat_q  <= pattern;
      inv_q  <= 1'b0;
    end else if (consume && remain != '0) begin
      remain <= remain - CW'(1);
      inv_q  <= pat_q[0];
      pat_q  <= pat_q >> 1;
    end
  end

  assign active  = (remain != '0);
  assign last    = (remain == CW'(1));
  assign cur_inv = inv_q;

  AST_REMAIN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CW'(MAX_SLOTS)); // R1
  AST_LOAD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> remain == $past(CW'(extra)) + CW'(1)); // R1
  AST_CONSUME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && active && !load && !clear) |=> remain == $past(remain) - CW'(1)); // R2
  AST_FIRST_SLOT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> !cur_inv); // R3
  AST_CLEAR_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !active); // R10
endmodule

// File: rtl/it_block_seq.sv
module it_block_seq
  import it_seq_pkg::*;
#(
  parameter int MAX_SLOTS = 4,
  localparam int EW = $clog2(MAX_SLOTS),
  localparam int PW = MAX_SLOTS - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_entry,
  input  logic          dir_valid,
  input  logic [3:0]    dir_cond,
  input  logic [EW-1:0] dir_extra,
  input  logic [PW-1:0] dir_pattern,
  input  logic          ins_valid,
  input  logic          ins_writes_pc,
  input  logic          flag_n,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic          flag_v,
  output logic          in_block,
  output logic          last_slot,
  output logic          exec_en,
  output logic          bad_place,
  output logic          flag_lock
);
  logic              active;
  logic              last;
  logic              cur_inv;
  logic              pass;
  logic              load;
  logic              consume;
  logic [COND_W-1:0] cond_q;

  assign load    = dir_valid & ~active;
  assign consume = (ins_valid | dir_valid) & active;

  always_ff @(posedge clk) begin
    if (!rst_n || exc_entry)
      cond_q <= CND_AL;
    else if (load)
      cond_q <= dir_cond;
  end

  it_slot_tracker #(.MAX_SLOTS(MAX_SLOTS)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (exc_entry),
    .load    (load),
    .consume (consume),
    .extra   (dir_extra),
    .pattern (dir_pattern),
    .active  (active),
    .last    (last),
    .cur_inv (cur_inv)
  );

  it_cond_eval u_eval (
    .cond   (cond_q),
    .invert (cur_inv),
    .fn     (flag_n),
    .fz     (flag_z),
    .fc     (flag_c),
    .fv     (flag_v),
    .pass   (pass)
  );

  assign in_block  = active;
  assign last_slot = last;
  assign exec_en   = ~active | pass;
  assign flag_lock = active;
  assign bad_place = active & ((dir_valid) | (ins_valid & ins_writes_pc & ~last));

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dir_valid && ins_valid)); // R2
  AST_LAST_PC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_writes_pc && last_slot) |-> !bad_place); // R7
  AST_NESTED_KEEPS_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && in_block && !exc_entry) |=> cond_q == $past(cond_q)); // R8
endmodule

// File: tb/it_block_seq_test.sv
module it_block_seq_test;
  import it_seq_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n, exc_entry, dir_valid, ins_valid, ins_writes_pc;
  logic [3:0] dir_cond;
  logic [1:0] dir_extra;
  logic [2:0] dir_pattern;
  logic       flag_n, flag_z, flag_c, flag_v;
  logic       in_block, last_slot, exec_en, bad_place, flag_lock;

  int total = 0;
  int fails = 0;
  logic s_exec, s_in, s_last, s_bad, s_lock;

  always #10 clk = ~clk;

  it_block_seq uut (
    .clk(clk), .rst_n(rst_n), .exc_entry(exc_entry),
    .dir_valid(dir_valid), .dir_cond(dir_cond), .dir_extra(dir_extra),
    .dir_pattern(dir_pattern), .ins_valid(ins_valid), .ins_writes_pc(ins_writes_pc),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .in_block(in_block), .last_slot(last_slot), .exec_en(exec_en),
    .bad_place(bad_place), .flag_lock(flag_lock)
  );

  // {cond, nzcv, expected exec}
  localparam logic [8:0] VEC [17] = '{
    {CND_EQ, 4'b0100, 1'b1}, {CND_NE, 4'b0100, 1'b0},
    {CND_CS, 4'b0010, 1'b1}, {CND_CC, 4'b0010, 1'b0},
    {CND_MI, 4'b1000, 1'b1}, {CND_PL, 4'b0000, 1'b1},
    {CND_VS, 4'b0000, 1'b0}, {CND_VC, 4'b0000, 1'b1},
    {CND_HI, 4'b0010, 1'b1}, {CND_HI, 4'b0110, 1'b0},
    {CND_LS, 4'b0010, 1'b0}, {CND_GE, 4'b1001, 1'b1},
    {CND_LT, 4'b1000, 1'b1}, {CND_GT, 4'b0000, 1'b1},
    {CND_GT, 4'b0100, 1'b0}, {CND_LE, 4'b0001, 1'b1},
    {CND_AL, 4'b0000, 1'b1}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic sample();
    s_exec = exec_en; s_in = in_block; s_last = last_slot;
    s_bad = bad_place; s_lock = flag_lock;
  endtask

  task automatic dir(input logic [3:0] c, input logic [1:0] ex, input logic [2:0] p);
    dir_valid = 1'b1; dir_cond = c; dir_extra = ex; dir_pattern = p;
    #2 sample();
    @(negedge clk);
    dir_valid = 1'b0;
  endtask

  task automatic ins(input logic wpc, input logic [3:0] nzcv);
    ins_valid = 1'b1; ins_writes_pc = wpc;
    {flag_n, flag_z, flag_c, flag_v} = nzcv;
    #2 sample();
    @(negedge clk);
    ins_valid = 1'b0; ins_writes_pc = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; exc_entry = 1'b0; dir_valid = 1'b0; ins_valid = 1'b0;
    ins_writes_pc = 1'b0; dir_cond = 4'd0; dir_extra = 2'd0; dir_pattern = 3'd0;
    {flag_n, flag_z, flag_c, flag_v} = 4'b0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R5 reset in_block", in_block, 1'b0);
    chk("R5 reset exec_en", exec_en, 1'b1);
    chk("R9 reset flag_lock", flag_lock, 1'b0);
    chk("R2 reset last_slot", last_slot, 1'b0);
    @(negedge clk);

    // R4 condition table walk, one-slot blocks (R1)
    for (int i = 0; i < 17; i++) begin
      dir(VEC[i][8:5], 2'd0, 3'd0);
      ins(1'b0, VEC[i][4:1]);
      chk($sformatf("R4 cond %0d row %0d", VEC[i][8:5], i), s_exec, VEC[i][0]);
      chk("R1 single slot is last", s_last, 1'b1);
    end
    #2 chk("R2 block closed after single slot", in_block, 1'b0);
    @(negedge clk);

    // R3 pattern T E T E with Z=1
    dir(CND_EQ, 2'd3, 3'b101);
    ins(1'b0, 4'b0100); chk("R3 slot0 base", s_exec, 1'b1); chk("R9 lock in block", s_lock, 1'b1);
    ins(1'b0, 4'b0100); chk("R3 slot1 else", s_exec, 1'b0); chk("R1 slot1 in block", s_in, 1'b1);
    ins(1'b0, 4'b0100); chk("R3 slot2 then", s_exec, 1'b1); chk("R2 slot2 not last", s_last, 1'b0);
    ins(1'b0, 4'b0100); chk("R3 slot3 else", s_exec, 1'b0); chk("R2 slot3 last", s_last, 1'b1);
    #2 chk("R2 closed after four", in_block, 1'b0);
    chk("R9 lock released", flag_lock, 1'b0);
    @(negedge clk);

    // R6 flags fresh per slot
    dir(CND_NE, 2'd1, 3'b000);
    ins(1'b0, 4'b0000); chk("R6 slot0 Z=0", s_exec, 1'b1);
    ins(1'b0, 4'b0100); chk("R6 slot1 Z=1", s_exec, 1'b0);

    // R2 idle cycles consume nothing
    dir(CND_MI, 2'd0, 3'b000);
    @(negedge clk); @(negedge clk);
    #2 chk("R2 idle keeps block", in_block, 1'b1);
    @(negedge clk);
    ins(1'b0, 4'b1000); chk("R2 idle then last", s_last, 1'b1); chk("R4 MI after idle", s_exec, 1'b1);

    // R7 placement of pc writers
    dir(CND_AL, 2'd1, 3'b000);
    ins(1'b1, 4'b0000); chk("R7 pc write mid block", s_bad, 1'b1);
    ins(1'b1, 4'b0000); chk("R7 pc write last slot", s_bad, 1'b0);
    ins(1'b1, 4'b0000); chk("R7 pc write outside", s_bad, 1'b0);
    chk("R5 outside exec", s_exec, 1'b1); chk("R5 outside in_block", s_in, 1'b0);

    // R8 nested directive
    dir(CND_EQ, 2'd1, 3'b000);
    dir(CND_CS, 2'd0, 3'b000); chk("R8 nested directive flagged", s_bad, 1'b1);
    ins(1'b0, 4'b0100);
    chk("R8 slot consumed", s_last, 1'b1);
    chk("R8 condition kept", s_exec, 1'b1);
    #2 chk("R8 block ended", in_block, 1'b0);
    @(negedge clk);

    // R10 exception entry
    dir(CND_EQ, 2'd3, 3'b000);
    ins(1'b0, 4'b0100);
    exc_entry = 1'b1;
    @(negedge clk);
    exc_entry = 1'b0;
    #2 chk("R10 exception closes block", in_block, 1'b0);
    chk("R9 lock off after exception", flag_lock, 1'b0);
    @(negedge clk);
    ins(1'b0, 4'b0000); chk("R10 after exception unconditional", s_exec, 1'b1);

    // R10 reset mid block
    dir(CND_EQ, 2'd2, 3'b000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #2 chk("R10 reset closes block", in_block, 1'b0);
    @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule